// File: doc/BRIEF.md
# Boundary-Register Parallel Signature Compactor

This block is a 16-bit boundary register that compresses parallel pin data into a signature. Test software first shifts a seed into it through a serial scan path. On every rising test-clock edge with the compress enable high, the eight sampled input-pin values are folded into the running signature. The pin byte is replicated across both halves of the word and XORed into a linear-feedback step of the current state.

After each compression edge, the new signature is copied into the core-side shadow bank on the following falling edge. That bank drives the on-chip logic. The pin-side shadow bank keeps driving the device outputs with its previous value for the whole compression run. It reloads only on a falling edge that follows a normal update edge.

With the compress enable low and the shift enable high, the register shifts toward bit 0. The finished signature therefore leaves on the serial output least significant bit first. A small state machine records which operation the last rising edge performed. It has four states: IDLE (no operation), SHIFT (serial scan), COMP (compression step) and UPD (normal update). The falling-edge shadow loads are decoded from that recorded state. The transition into each state is taken from the controls on every rising edge: COMP when the compress enable is high, otherwise SHIFT when the shift enable is high, otherwise UPD when the update request is high, otherwise IDLE.

Top module: `bsr_sig_compactor`

## Requirements
- R1: While rst_n is low, the register, both shadow banks and scan_out are all zero.
- R2: On a rising edge with shift_en high and sig_en low, the register moves one place toward bit 0 and scan_in enters bit 15. scan_out always shows bit 0, so a signature is unloaded least significant bit first.
- R3: On a rising edge with sig_en high, the register becomes S' = L(S) XOR {pin_in, pin_in}. L shifts left by one, and when the old bit 15 was 1 it XORs in 16'hA011 (polynomial x^16+x^15+x^13+x^4+1).
- R4: On the falling edge after a compression edge, core_drv takes the new register value.
- R5: pin_drv does not change after a rising edge in the COMP, SHIFT or IDLE state.
- R6: On a rising edge with upd_req high and sig_en and shift_en low, the register holds. On the following falling edge, pin_drv takes register bits 7..0 and core_drv takes the whole register.
- R7: The controls have a fixed priority: sig_en over shift_en over upd_req. A compression edge with shift_en also high compresses and does not shift.
- R8: An all-zero seed compressed with all-zero pins stays all zero.
- R9: With no control high, the register and both shadow banks hold their values.
- R10: core_drv keeps its value across serial shift edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock; operations on rising edge, shadow loads on falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sig_en | input | 1 | Compress enable |
| shift_en | input | 1 | Serial scan enable |
| upd_req | input | 1 | Normal update request |
| pin_in | input | 8 | Sampled device input pins |
| scan_in | input | 1 | Serial scan data in |
| scan_out | output | 1 | Serial scan data out (register bit 0) |
| core_drv | output | 16 | Core-side shadow bank, drives on-chip logic |
| pin_drv | output | 8 | Pin-side shadow bank, drives device outputs |

## Verification
The assertions assume that controls, pin data and scan data change only between a falling edge and the next rising edge. This keeps the values seen at each rising edge well defined. The bench meets this by driving every input 8 ns after a rising edge, which is after the falling edge that performs the shadow loads. The assertions also assume the reset is released away from a clock edge, and the bench releases it mid-cycle.

// File: rtl/bsr_sig_pkg.sv
package bsr_sig_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_COMP  = 2'd2,
        ST_UPD   = 2'd3
    } bsr_mode_e;
endpackage

// File: rtl/bsr_mode_fsm.sv
module bsr_mode_fsm
    import bsr_sig_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sig_en,
    input  logic      shift_en,
    input  logic      upd_req,
    output bsr_mode_e mode_d,
    output bsr_mode_e mode_q,
    output logic      core_ld,
    output logic      pin_ld
);
    // transition choice by fixed priority (R7)
    always_comb begin
        if (sig_en)        mode_d = ST_COMP;
        else if (shift_en) mode_d = ST_SHIFT;
        else if (upd_req)  mode_d = ST_UPD;
        else               mode_d = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= ST_IDLE;
        else        mode_q <= mode_d;
    end

    // falling-edge load strobes decoded from the recorded operation
    always_comb begin
        core_ld = 1'b0;
        pin_ld  = 1'b0;
        unique case (mode_q)
            ST_IDLE:  ;
            ST_SHIFT: ;
            ST_COMP:  core_ld = 1'b1;
            ST_UPD: begin
                core_ld = 1'b1;
                pin_ld  = 1'b1;
            end
            default:  ;
        endcase
    end
endmodule

// File: rtl/bsr_chain.sv
module bsr_chain
    import bsr_sig_pkg::*;
#(
    parameter int          W    = 16,
    parameter int          N    = 8,
    parameter logic [W-1:0] POLY = 16'hA011
) (
    input  logic         clk,
    input  logic         rst_n,
    input  bsr_mode_e    mode_d,
    input  logic [N-1:0] pin_in,
    input  logic         scan_in,
    output logic [W-1:0] chain_q
);
    localparam int REP = W / N;

    logic [W-1:0] par_vec;
    logic [W-1:0] lfsr_nx;
    logic [W-1:0] chain_d;

    genvar g;
    generate
        for (g = 0; g < REP; g++) begin : g_rep
            assign par_vec[g*N +: N] = pin_in;
        end
    endgenerate

    always_comb begin
        lfsr_nx = {chain_q[W-2:0], 1'b0};
        if (chain_q[W-1]) lfsr_nx = lfsr_nx ^ POLY;
    end

    always_comb begin
        chain_d = chain_q;
        unique case (mode_d)
            ST_COMP:  chain_d = lfsr_nx ^ par_vec;
            ST_SHIFT: chain_d = {scan_in, chain_q[W-1:1]};
            ST_UPD:   chain_d = chain_q;
            ST_IDLE:  chain_d = chain_q;
            default:  chain_d = chain_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end
endmodule

// File: rtl/bsr_shadow.sv
module bsr_shadow #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (ld) q <= d;
    end
endmodule

// File: rtl/bsr_sig_compactor.sv
module bsr_sig_compactor
    import bsr_sig_pkg::*;
#(
    parameter int           W    = 16,
    parameter int           N    = 8,
    parameter logic [W-1:0] POLY = 16'hA011
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sig_en,
    input  logic         shift_en,
    input  logic         upd_req,
    input  logic [N-1:0] pin_in,
    input  logic         scan_in,
    output logic         scan_out,
    output logic [W-1:0] core_drv,
    output logic [N-1:0] pin_drv
);
    bsr_mode_e    mode_d;
    bsr_mode_e    mode_q;
    logic         core_ld;
    logic         pin_ld;
    logic [W-1:0] chain_q;

    bsr_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sig_en   (sig_en),
        .shift_en (shift_en),
        .upd_req  (upd_req),
        .mode_d   (mode_d),
        .mode_q   (mode_q),
        .core_ld  (core_ld),
        .pin_ld   (pin_ld)
    );

    bsr_chain #(.W(W), .N(N), .POLY(POLY)) u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_d  (mode_d),
        .pin_in  (pin_in),
        .scan_in (scan_in),
        .chain_q (chain_q)
    );

    bsr_shadow #(.W(W)) u_core_sh (
        .clk   (clk),
        .rst_n (rst_n),
        .ld    (core_ld),
        .d     (chain_q),
        .q     (core_drv)
    );

    bsr_shadow #(.W(N)) u_pin_sh (
        .clk   (clk),
        .rst_n (rst_n),
        .ld    (pin_ld),
        .d     (chain_q[N-1:0]),
        .q     (pin_drv)
    );

    assign scan_out = chain_q[0];
endmodule

// File: rtl/bsr_sig_checker.sv
module bsr_sig_checker
    import bsr_sig_pkg::*;
#(
    parameter int W = 16,
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         sig_en,
    input logic         shift_en,
    input logic         upd_req,
    input logic         scan_in,
    input logic [W-1:0] core_drv,
    input logic [N-1:0] pin_drv,
    input logic [W-1:0] chain_q,
    input bsr_mode_e    mode_q
);
    assert_shift_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !sig_en) |=> (chain_q[W-1] == $past(scan_in)));

    assert_core_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sig_en |=> (core_drv == chain_q));

    assert_pin_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sig_en || shift_en || !upd_req) |=> $stable(pin_drv));

    assert_update_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_req && !sig_en && !shift_en) |=> (pin_drv == chain_q[N-1:0]) && $stable(chain_q));

    assert_priority_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sig_en |=> (mode_q == ST_COMP));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sig_en && !shift_en && !upd_req) |=> $stable(chain_q) && $stable(core_drv));

    assert_core_shift_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !sig_en) |=> $stable(core_drv));
endmodule

bind bsr_sig_compactor bsr_sig_checker #(.W(W), .N(N)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sig_en   (sig_en),
    .shift_en (shift_en),
    .upd_req  (upd_req),
    .scan_in  (scan_in),
    .core_drv (core_drv),
    .pin_drv  (pin_drv),
    .chain_q  (chain_q),
    .mode_q   (mode_q)
);

// File: tb/bsr_sig_compactor_bench.sv
module bsr_sig_compactor_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sig_en = 1'b0;
    logic        shift_en = 1'b0;
    logic        upd_req = 1'b0;
    logic [7:0]  pin_in = '0;
    logic        scan_in = 1'b0;
    logic        scan_out;
    logic [15:0] core_drv;
    logic [7:0]  pin_drv;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    typedef struct {
        logic        so;
        logic [15:0] core;
        logic [7:0]  pout;
        string       tag;
    } exp_t;
    exp_t sb[$];

    logic [15:0] m_chain = '0;
    logic [15:0] m_core = '0;
    logic [7:0]  m_pout = '0;

    always #5 clk = ~clk;

    bsr_sig_compactor u_bsr_sig_compactor (
        .clk(clk), .rst_n(rst_n), .sig_en(sig_en), .shift_en(shift_en),
        .upd_req(upd_req), .pin_in(pin_in), .scan_in(scan_in),
        .scan_out(scan_out), .core_drv(core_drv), .pin_drv(pin_drv)
    );

    function automatic logic [15:0] sig_step(input logic [15:0] s, input logic [7:0] p);
        logic [15:0] n;
        n = {s[14:0], 1'b0};
        if (s[15]) n = n ^ 16'hA011;
        return n ^ {p, p};
    endfunction

    task automatic check(input string tag, input bit ok, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver: computes the expected result and queues it
    task automatic cyc(input bit se, input bit sh, input bit up, input logic [7:0] p,
                       input bit si, input string tag);
        exp_t e;
        if (se) begin
            m_chain = sig_step(m_chain, p);
            m_core  = m_chain;
        end else if (sh) begin
            m_chain = {si, m_chain[15:1]};
        end else if (up) begin
            m_core = m_chain;
            m_pout = m_chain[7:0];
        end
        e.so = m_chain[0]; e.core = m_core; e.pout = m_pout; e.tag = tag;
        sb.push_back(e);
        sig_en = se; shift_en = sh; upd_req = up; pin_in = p; scan_in = si;
        @(posedge clk);
        #8;
    endtask

    // monitor: compares after each falling edge
    always @(negedge clk) begin
        #2;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check(e.tag, {scan_out, core_drv, pin_drv} == {e.so, e.core, e.pout},
                  {7'd0, scan_out, core_drv, pin_drv}, {7'd0, e.so, e.core, e.pout});
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] seed;
        seed = 16'h5A3C;
        #12;
        check("R1 reset scan_out", scan_out == 1'b0, {31'd0, scan_out}, 32'd0);
        check("R1 reset core_drv", core_drv == 16'd0, {16'd0, core_drv}, 32'd0);
        check("R1 reset pin_drv", pin_drv == 8'd0, {24'd0, pin_drv}, 32'd0);
        rst_n = 1'b1;
        @(posedge clk); #8;

        // R2: scan seed in, LSB first
        for (int i = 0; i < 16; i++) cyc(0, 1, 0, 8'hFF, seed[i], "R2 seed shift");
        // R9: idle holds
        cyc(0, 0, 0, 8'h77, 1'b1, "R9 idle hold");
        // R6: update loads both banks
        cyc(0, 0, 1, 8'h00, 1'b0, "R6 update");
        // R3 R4 R5: compression stream
        for (int i = 0; i < 24; i++)
            cyc(1, 0, 1, 8'(i * 37 + 11), 1'b1, "R3 R4 R5 compress");
        // R7: compress beats shift
        cyc(1, 1, 0, 8'hC3, 1'b1, "R7 priority compress");
        cyc(0, 1, 1, 8'h00, 1'b1, "R7 shift beats update R10");
        // R2 R10: unload the final signature LSB first
        for (int i = 0; i < 16; i++) cyc(0, 1, 0, 8'h00, 1'b0, "R2 R10 unload");
        // R8: zero seed with zero pins
        for (int i = 0; i < 6; i++) cyc(1, 0, 0, 8'h00, 1'b0, "R8 zero stays zero");
        cyc(0, 0, 1, 8'h00, 1'b0, "R6 update zero");
        // further stream after a fresh seed
        for (int i = 0; i < 16; i++) cyc(0, 1, 0, 8'h00, 1'(i % 3 == 0), "R2 reseed");
        for (int i = 0; i < 10; i++) cyc(1, 0, 0, 8'(8'hA5 ^ 8'(i)), 1'b0, "R3 R5 compress 2");
        for (int i = 0; i < 16; i++) cyc(0, 1, 0, 8'h00, 1'b0, "R2 unload 2");
        @(posedge clk); #8;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule